// File: doc/BRIEF.md
# Single-Channel PWM with Reload Interrupt

The block is one pulse-width modulator channel that runs from a tick enable. Each PWM period lasts a programmable number of ticks. The output is high from the first tick of a period until a high-time count is reached, and low for the rest of the period. The high time comes from a width byte. A 2-bit resolution code chooses whether the full byte or only its upper 7, 6 or 5 bits set the count.

Software writes new widths into a shadow register. The shadow is copied into the active register at every period boundary, so a pulse is never altered partway through. A reload counter counts period boundaries. Every (N+1) boundaries, if the interrupt is enabled, it raises a request flag that asks software for the next width. If no new width arrives, the shadow still holds the old value and the next pulses repeat it. The flag sits in a status register that clears when it is read.

All access goes through a simple byte register port with a 3-bit address. The map is:

| Address | Register | Access |
|---|---|---|
| 0 | width shadow | read/write |
| 1 | reload interval N | read/write |
| 2 | period P | read/write |
| 3 | config | read/write |
| 4 | status | read only, clears the flag when read |

Top module: `pwm_reload_chan`

## Requirements
- R1: After reset, `pwm_out` and `irq` are 0. The status, width, interval, period and config registers all read 0.
- R2: When config bits [1:0] are 3, the high time equals the full active width byte, counted in ticks.
- R3: Config codes 2, 1 and 0 set the high time to active width bits [7:1], [7:2] and [7:3], counted in ticks. A new code applies from the cycle after it is written.
- R4: A period lasts P+1 ticks, where P is the value at address 2. The output is high while the tick position within the period is below the high time.
- R5: A high time of 0 keeps `pwm_out` low for the whole period. A high time of P+1 or more keeps it high for the whole period.
- R6: A write to address 0 changes only the shadow register. The active width takes the shadow value at the next period boundary, which is the tick that ends a period.
- R7: If no new width is written, each following period repeats the previous width.
- R8: When config bit 2 is 1, the status flag is set at every (N+1)-th period boundary. N is the value at address 1, and `irq` follows the flag.
- R9: When config bit 2 is 0, the flag is never set.
- R10: A read of address 4 returns the flag in bit 0, with bits [7:1] equal to 0. The read clears the flag in the next cycle.
- R11: If a status read and a flag-setting boundary fall on the same cycle, the flag stays set.
- R12: The period position advances only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable; one tick per asserted cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; combinational from addr |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Reload request, equal to the status flag |

## Verification
A wrong period position or a wrong active width shows up on `pwm_out` within one period. The output edge moves, appears or disappears, and a per-cycle comparison catches this at the first differing clock. A corrupted reload count shows up as an `irq` rise at the wrong boundary, which can take up to N+1 periods to appear. A lost clear or a lost set is seen on `irq` on the cycle right after the read. The same-cycle collision is forced on purpose, by timing a status read to land exactly on a flag-setting boundary.

// File: rtl/pwm_reload_chan.sv
module pwm_reload_chan #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pwm_out,
  output logic          irq
);
  localparam logic [AW-1:0] A_WIDTH  = AW'(0);
  localparam logic [AW-1:0] A_IVAL   = AW'(1);
  localparam logic [AW-1:0] A_PERIOD = AW'(2);
  localparam logic [AW-1:0] A_CFG    = AW'(3);
  localparam logic [AW-1:0] A_STAT   = AW'(4);

  logic [DW-1:0] shadow, active, ival, period, cnt, pcnt, hi;
  logic [2:0]    cfg;
  logic          flag;

  wire bnd    = tick && (cnt >= period);
  wire setev  = bnd && (pcnt >= ival) && cfg[2];
  wire rd_st  = rd_en && (addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      ival   <= '0;
      period <= '0;
      cfg    <= '0;
      cnt    <= '0;
      pcnt   <= '0;
      flag   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_WIDTH:  shadow <= wdata;
          A_IVAL:   ival   <= wdata;
          A_PERIOD: period <= wdata;
          A_CFG:    cfg    <= wdata[2:0];
          default: ;
        endcase
      end
      if (tick) cnt <= bnd ? '0 : cnt + 1'b1;
      if (bnd) begin
        active <= shadow;
        pcnt   <= (pcnt >= ival) ? '0 : pcnt + 1'b1;
      end
      if (setev)      flag <= 1'b1;
      else if (rd_st) flag <= 1'b0;
    end
  end

  assign hi      = active >> (2'd3 - cfg[1:0]);
  assign pwm_out = cnt < hi;
  assign irq     = flag;

  always_comb begin
    case (addr)
      A_WIDTH:  rdata = shadow;
      A_IVAL:   rdata = ival;
      A_PERIOD: rdata = period;
      A_CFG:    rdata = {{(DW-3){1'b0}}, cfg};
      A_STAT:   rdata = {{(DW-1){1'b0}}, flag};
      default:  rdata = '0;
    endcase
  end

  assert_active_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> $past(bnd));
  assert_hold_without_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  assert_irq_rise_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bnd && cfg[2]));
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !setev) |=> !irq);
  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && setev) |=> irq);
endmodule

// File: tb/pwm_reload_chan_tb.sv
module pwm_reload_chan_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic pwm_out, irq;

  pwm_reload_chan u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, tick_mode = 0;
  bit started = 0, done = 0;
  string cur_req = "R1";

  int m_sh = 0, m_act = 0, m_iv = 0, m_per = 0, m_cfg = 0, m_cnt = 0, m_pc = 0, m_flag = 0;

  always @(posedge clk) begin
    #1;
    case (tick_mode)
      0: tick = 1;
      1: tick = ~tick;
      default: tick = 0;
    endcase
  end

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_sh = 0; m_act = 0; m_iv = 0; m_per = 0; m_cfg = 0; m_cnt = 0; m_pc = 0; m_flag = 0;
    end else begin
      bit b, s;
      int o_sh, o_iv;
      b = tick && (m_cnt >= m_per);
      s = b && (m_pc >= m_iv) && ((m_cfg & 4) != 0);
      o_sh = m_sh; o_iv = m_iv;
      if (wr_en) begin
        if (addr == 0) m_sh = wdata;
        if (addr == 1) m_iv = wdata;
        if (addr == 2) m_per = wdata;
        if (addr == 3) m_cfg = wdata & 7;
      end
      if (tick) m_cnt = b ? 0 : m_cnt + 1;
      if (b) begin
        m_act = o_sh;
        m_pc = (m_pc >= o_iv) ? 0 : m_pc + 1;
      end
      if (s) m_flag = 1;
      else if (rd_en && addr == 4) m_flag = 0;
    end
  end

  function automatic int exp_pwm();
    int h;
    h = m_act >> (3 - (m_cfg & 3));
    return (m_cnt < h) ? 1 : 0;
  endfunction

  function automatic int exp_rd();
    case (addr)
      0: return m_sh;
      1: return m_iv;
      2: return m_per;
      3: return m_cfg;
      4: return m_flag;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(pwm_out === exp_pwm()[0], {cur_req, " pwm_out"}, pwm_out, exp_pwm());
      chk(irq === m_flag[0], {cur_req, " irq"}, irq, m_flag);
      if (rd_en) chk(rdata === exp_rd()[7:0], {cur_req, " rdata"}, rdata, exp_rd());
    end
  end

  task automatic cyc(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1, 0, a, d);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    idle(3);
    for (int a = 0; a < 5; a++) cyc(0, 1, a[2:0], 0);
    @(posedge clk); #2; rst_n = 1; rd_en = 0;
    idle(2);
    @(negedge clk);
    chk(pwm_out === 1'b0 && irq === 1'b0, "R1 reset outputs", {pwm_out, irq}, 0);
    for (int a = 0; a < 5; a++) cyc(0, 1, a[2:0], 0);

    cur_req = "R2";
    wr(2, 15); wr(3, 3); wr(0, 10);
    idle(60);
    cur_req = "R4";
    wr(2, 7);
    idle(40);
    wr(2, 15);

    cur_req = "R3";
    wr(3, 2); idle(40);
    wr(3, 1); idle(40);
    wr(3, 0); idle(40);
    wr(0, 8'hB0); idle(40);

    cur_req = "R6";
    wr(3, 3); wr(0, 4); idle(21);
    wr(0, 12); idle(3);
    @(negedge clk);
    chk(pwm_out === exp_pwm()[0], "R6 shadow not yet active", pwm_out, exp_pwm());
    idle(40);

    cur_req = "R7";
    idle(80);

    cur_req = "R5";
    wr(0, 0); idle(40);
    wr(0, 8'hFF); idle(40);
    wr(0, 16); idle(40);
    wr(0, 6);

    cur_req = "R8";
    wr(1, 2); wr(3, 7);
    idle(110);
    @(negedge clk);
    chk(irq === 1'b1, "R8 irq after N+1 periods", irq, 1);
    cur_req = "R10";
    cyc(0, 1, 4, 0);
    @(negedge clk);
    chk(rdata === 8'h01, "R10 status value", rdata, 1);
    cyc(0, 0, 0, 0);
    @(negedge clk);
    chk(irq === 1'b0, "R10 cleared by read", irq, 0);
    idle(60);

    cur_req = "R11";
    begin
      bit hit = 0;
      while (!hit) begin
        @(posedge clk); #2;
        wr_en = 0; addr = 4;
        if (tick && m_cnt >= m_per && m_pc >= m_iv && (m_cfg & 4) != 0) begin
          rd_en = 1; hit = 1;
        end else rd_en = (m_flag != 0);
      end
    end
    cyc(0, 0, 0, 0);
    @(negedge clk);
    chk(irq === 1'b1, "R11 set wins over clear", irq, 1);
    cyc(0, 1, 4, 0);
    idle(5);

    cur_req = "R9";
    wr(3, 3);
    idle(150);
    @(negedge clk);
    chk(irq === 1'b0, "R9 no irq when disabled", irq, 0);

    cur_req = "R12";
    wr(3, 6);
    tick_mode = 1; idle(120);
    tick_mode = 2; idle(30);
    @(negedge clk);
    chk(pwm_out === exp_pwm()[0], "R12 frozen without tick", pwm_out, exp_pwm());
    tick_mode = 0; idle(60);

    finish_run();
  end
endmodule